// File: doc/BRIEF.md
# Serial transmit FIFO controller

This block is the transmit side of a synchronous serial port that drives its own serial clock. A CPU-side byte write port feeds either a four-entry FIFO or, when the FIFO is switched off, the holding register directly. Behind the FIFO sits a two-stage transmit buffer: a holding register that feeds a shift register. The shift register sends each byte most significant bit first on a clock output that is divided down from the system clock.

The FIFO can raise a fill-level interrupt. When a byte moves from the FIFO into the holding register and leaves exactly the programmed number of bytes behind, a one-cycle pulse is raised. With auto-stop set, that same transfer freezes the FIFO side. No further bytes leave the FIFO. The serial clock stops once the bytes already in the two-stage buffer have been shifted out. A clear input empties the FIFO in a single cycle. It also lifts the freeze and the overrun flag, so software can apply it together with a new interrupt level.

Top module: `sertx_fifo_ctrl`

## Requirements
- R1: After reset, buf_empty is 1, sclk_out is 1, sdata_out is 1, tx_int is 0 and overrun is 0.
- R2: With fifo_en = 0, a write goes straight into the holding register when that register is empty. The byte is then sent unchanged.
- R3: With fifo_en = 1, the FIFO holds 4 bytes besides the holding register. A write that finds no free place is dropped and sets overrun. overrun stays 1 until fifo_clr.
- R4: Each byte is sent MSB first. Each bit lasts DIV system clocks: sclk_out is low for the first DIV/2 clocks and high for the rest. sdata_out changes as sclk_out falls. Both lines are high while nothing is shifting.
- R5: A byte moves from the holding register into the shift register only while tx_en = 1. Data written while tx_en = 0 waits and is not sent.
- R6: Bytes leave in write order. When the holding register is full as a byte completes, the next byte follows with no idle clock, so n bytes take n*8*DIV clocks.
- R7: tx_int is a one-clock pulse. It is raised in the clock after a FIFO-to-holding transfer that leaves exactly int_level bytes in the FIFO, so it comes before that byte is shifted. A level of 0 fires on the transfer of the last byte.
- R8: With auto_stop = 1, no FIFO byte is transferred after the interrupting transfer. The remaining buffered bytes are sent and sclk_out then stays high.
- R9: fifo_clr empties the FIFO in one clock and clears overrun and the auto-stop freeze. It leaves the holding register untouched.
- R10: buf_empty is 1 exactly when the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DW | Byte to write |
| fifo_en | input | 1 | 1 routes writes through the FIFO |
| fifo_clr | input | 1 | Empties the FIFO; clears overrun and the freeze |
| int_level | input | clog2(DEPTH) | Fill level that raises the interrupt |
| auto_stop | input | 1 | Freeze the FIFO side at the fill level |
| tx_en | input | 1 | Allows bytes into the shift register |
| sclk_out | output | 1 | Serial clock, idles high |
| sdata_out | output | 1 | Serial data, MSB first |
| buf_empty | output | 1 | Holding register is empty |
| tx_int | output | 1 | Fill-level interrupt pulse |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
A write is registered at the first clock edge. The holding register takes it from the FIFO at the next edge, and tx_int shows in the clock after that transfer. The shift register loads at the edge after the holding register becomes full with tx_en high, and sclk_out falls at that same edge. The bench drives inputs and samples outputs on falling system-clock edges, so each value is read half a clock after the edge that set it. A bench-side receiver samples sdata_out on each rising sclk_out. The bench records how many bytes had arrived when each tx_int pulse was seen, and checks that count against 3 - int_level for every level and stop setting. Checks that depend on long transfers wait a bounded number of clocks; the contiguous-stream check requires five bytes within 5*8*DIV clocks.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // FIFO occupancy after one clock with an optional pop and push.
    function automatic int fill_after(int cnt, logic pop, logic push);
        return cnt - (pop ? 1 : 0) + (push ? 1 : 0);
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_q, st_d;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = bump(st_q.wp);
            if (pop)  st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= din;
    end

    assign dout  = mem[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DW  = 8,
    parameter int DIV = 4,
    localparam int BW = $clog2(DW),
    localparam int VW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic          take,
    output logic          busy,
    output logic          sclk,
    output logic          sdata
);
    typedef struct packed {
        logic          busy;
        logic [BW-1:0] bitn;
        logic [VW-1:0] div;
        logic [DW-1:0] sr;
    } sst_t;

    sst_t st_q, st_d;
    logic last_tick;

    assign last_tick = (st_q.div == VW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.bitn = '0;
            st_d.div  = '0;
            st_d.sr   = din;
        end else if (st_q.busy) begin
            if (last_tick) begin
                st_d.div = '0;
                if (st_q.bitn == BW'(DW - 1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                    st_d.sr   = {st_q.sr[DW-2:0], 1'b0};
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take  = !st_q.busy || (last_tick && st_q.bitn == BW'(DW - 1));
    assign busy  = st_q.busy;
    assign sclk  = !st_q.busy || (st_q.div >= VW'(DIV / 2));
    assign sdata = st_q.busy ? st_q.sr[DW-1] : 1'b1;
endmodule

// File: rtl/sertx_fifo_ctrl.sv
module sertx_fifo_ctrl
    import sertx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int DIV   = 4,
    localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_en,
    input  logic          fifo_clr,
    input  logic [LW-1:0] int_level,
    input  logic          auto_stop,
    input  logic          tx_en,
    output logic          sclk_out,
    output logic          sdata_out,
    output logic          buf_empty,
    output logic          tx_int,
    output logic          overrun
);
    typedef struct packed {
        logic          hold_valid;
        logic [DW-1:0] hold_data;
        logic          overrun;
        logic          halted;
        logic          tx_int;
    } cst_t;

    cst_t st_q, st_d;

    logic [DW-1:0] f_dout;
    logic [CW-1:0] f_count;
    logic          f_full, f_empty;
    logic          pop, push, direct, load, reached;
    logic          sh_take, sh_busy, halted;

    sertx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (push),
        .din  (wr_data),
        .pop  (pop),
        .dout (f_dout),
        .count(f_count),
        .full (f_full),
        .empty(f_empty)
    );

    sertx_shifter #(.DW(DW), .DIV(DIV)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (st_q.hold_data),
        .take (sh_take),
        .busy (sh_busy),
        .sclk (sclk_out),
        .sdata(sdata_out)
    );

    always_comb begin
        pop     = fifo_en && !f_empty && !st_q.hold_valid && !st_q.halted && !fifo_clr;
        push    = fifo_en && wr_en && !fifo_clr && (!f_full || pop);
        direct  = !fifo_en && wr_en && !st_q.hold_valid;
        load    = st_q.hold_valid && tx_en && sh_take;
        reached = pop && (fill_after(int'(f_count), pop, push) == int'(int_level));

        st_d        = st_q;
        st_d.tx_int = reached;
        if (load)   st_d.hold_valid = 1'b0;
        if (pop)    begin st_d.hold_valid = 1'b1; st_d.hold_data = f_dout;  end
        if (direct) begin st_d.hold_valid = 1'b1; st_d.hold_data = wr_data; end
        if (fifo_clr) begin
            st_d.overrun = 1'b0;
            st_d.halted  = 1'b0;
        end else begin
            if (wr_en && !push && !direct) st_d.overrun = 1'b1;
            if (reached && auto_stop)      st_d.halted  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted    = st_q.halted;
    assign buf_empty = !st_q.hold_valid;
    assign tx_int    = st_q.tx_int;
    assign overrun   = st_q.overrun;
endmodule

// File: rtl/sertx_fifo_ctrl_chk.sv
module sertx_fifo_ctrl_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          tx_int,
    input logic          overrun,
    input logic          sclk_out,
    input logic          sdata_out,
    input logic          busy,
    input logic          halted,
    input logic          pop,
    input logic [CW-1:0] fill
);
    p_int_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |=> !tx_int);

    p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_out && sdata_out));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !fifo_clr) |=> overrun);

    p_halt_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !pop);

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fill == '0 && !overrun));
endmodule

bind sertx_fifo_ctrl sertx_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_clr (fifo_clr),
    .tx_int   (tx_int),
    .overrun  (overrun),
    .sclk_out (sclk_out),
    .sdata_out(sdata_out),
    .busy     (sh_busy),
    .halted   (halted),
    .pop      (pop),
    .fill     (f_count)
);

// File: tb/sertx_fifo_ctrl_test.sv
`timescale 1ns/1ps
module sertx_fifo_ctrl_test;
    localparam int DW = 8, DEPTH = 4, DIV = 4;
    localparam int BYTE_CYC = 8 * DIV;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, fifo_en = 1'b0, fifo_clr = 1'b0;
    logic       auto_stop = 1'b0, tx_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] int_level = '0;
    logic       sclk_out, sdata_out, buf_empty, tx_int, overrun;

    int tests = 0, fails = 0;
    int rxn = 0, bitn = 0, intcnt = 0, int_rx = 0, lowcnt = 0;
    logic [7:0] rxsh = '0;
    logic [7:0] rxb [64];
    logic [7:0] expb [64];

    always #4 clk = ~clk;

    sertx_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .fifo_clr(fifo_clr), .int_level(int_level),
        .auto_stop(auto_stop), .tx_en(tx_en), .sclk_out(sclk_out),
        .sdata_out(sdata_out), .buf_empty(buf_empty), .tx_int(tx_int),
        .overrun(overrun)
    );

    // Bench receiver: samples data on each rising serial clock.
    always @(posedge sclk_out) begin
        if (rst_n) begin
            rxsh = {rxsh[6:0], sdata_out};
            bitn = bitn + 1;
            if (bitn == 8) begin
                rxb[rxn % 64] = rxsh;
                rxn  = rxn + 1;
                bitn = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && tx_int) begin
            intcnt = intcnt + 1;
            int_rx = rxn;
        end
        if (rst_n && !sclk_out) lowcnt = lowcnt + 1;
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int base, t, nb;
        logic [7:0] v;

        // R1: reset state
        idle(3);
        chk("R1 buf_empty", int'(buf_empty), 1);
        chk("R1 sclk_out", int'(sclk_out), 1);
        chk("R1 sdata_out", int'(sdata_out), 1);
        chk("R1 tx_int", int'(tx_int), 0);
        chk("R1 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        idle(2);

        // R2, R5, R10, R4: direct path, held until tx_en
        base = rxn;
        wr(8'hA5);
        chk("R10 buf_empty after write", int'(buf_empty), 0);
        idle(60);
        chk("R5 nothing sent while tx_en=0", rxn - base, 0);
        chk("R5 sclk idle while tx_en=0", int'(sclk_out), 1);
        lowcnt = 0;
        tx_en = 1'b1;
        idle(BYTE_CYC + 6);
        chk("R2 one byte sent", rxn - base, 1);
        chk("R2 R4 byte value MSB first", int'(rxb[base % 64]), 'hA5);
        chk("R4 low clocks per byte", lowcnt, 8 * (DIV / 2));
        chk("R4 sdata idle high", int'(sdata_out), 1);
        chk("R10 buf_empty after send", int'(buf_empty), 1);

        // R3, R6, R9: capacity, overrun, order, contiguity
        tx_en = 1'b0;
        fifo_en = 1'b1;
        int_level = 2'd3;
        clear();
        base = rxn;
        for (int k = 0; k < 5; k++) begin
            expb[k] = 8'(8'h31 + k * 37);
            wr(expb[k]);
        end
        chk("R3 no overrun at five bytes", int'(overrun), 0);
        wr(8'hEE);
        chk("R3 overrun on sixth byte", int'(overrun), 1);
        idle(1);
        tx_en = 1'b1;
        t = 0;
        while (rxn - base < 5 && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk("R6 five bytes contiguous in 5*8*DIV", int'(t <= 5 * BYTE_CYC), 1);
        for (int k = 0; k < 5; k++)
            chk("R6 byte order", int'(rxb[(base + k) % 64]), int'(expb[k]));
        idle(BYTE_CYC);
        chk("R3 dropped byte not sent", rxn - base, 5);
        chk("R3 overrun sticky", int'(overrun), 1);
        clear();
        chk("R9 clear resets overrun", int'(overrun), 0);

        // R7, R8: sweep fill level and auto-stop
        for (int a = 0; a < 2; a++) begin
            for (int lv = 0; lv < 4; lv++) begin
                tx_en = 1'b0;
                clear();
                int_level = 2'(lv);
                auto_stop = 1'(a);
                fifo_en = 1'b0;
                v = 8'(lv * 40 + a * 20 + 7);
                expb[0] = v;
                wr(v);
                fifo_en = 1'b1;
                for (int k = 1; k < 5; k++) begin
                    expb[k] = 8'(lv * 40 + a * 20 + k * 3 + 7);
                    wr(expb[k]);
                end
                chk("R7 no pulse before tx_en", int'(tx_int), 0);
                base = rxn;
                t = intcnt;
                tx_en = 1'b1;
                idle(6 * BYTE_CYC);
                nb = (a == 1) ? (5 - lv) : 5;
                chk("R8 bytes sent", rxn - base, nb);
                for (int k = 0; k < nb; k++)
                    chk("R6 R8 sweep byte order", int'(rxb[(base + k) % 64]), int'(expb[k]));
                chk("R7 one interrupt pulse", intcnt - t, 1);
                chk("R7 pulse at transfer, not after shift", int_rx - base, 3 - lv);
                chk("R8 serial clock stopped", int'(sclk_out), 1);
                chk("R8 buffer empty at end", int'(buf_empty), 1);
            end
        end

        // R9: clear drops FIFO bytes but keeps the holding byte
        tx_en = 1'b0;
        auto_stop = 1'b0;
        clear();
        base = rxn;
        for (int k = 0; k < 5; k++) wr(8'(8'hC0 + k));
        clear();
        chk("R9 holding kept after clear", int'(buf_empty), 0);
        tx_en = 1'b1;
        idle(3 * BYTE_CYC);
        chk("R9 only holding byte sent", rxn - base, 1);
        chk("R9 holding byte value", int'(rxb[base % 64]), 'hC0);

        summary();
    end
endmodule